// File: doc/BRIEF.md
# Receive-Side Software Flow Control Filter

This block sits between a serial receiver and its receive FIFO. Every character the receiver hands over is compared against four programmable match characters: two that resume the far-end transmitter's partner (resume-first, resume-second) and two that halt it (halt-first, halt-second). Depending on the selected mode, a match on a single character or on an ordered pair of characters drives a level that tells the local transmitter to pause or to continue. Characters recognised as flow control are consumed. All others are passed on to the FIFO write port unchanged.

A feature register selects the matching mode and enables special-character detection. Special-character detection raises a one-cycle interrupt request whenever the received byte equals the halt-second character. One bit of the feature register acts as a write unlock: while it is clear, the four match registers are frozen. All outputs are registered, so the effect of an accepted character appears in the cycle after it is presented.

Top module: `sw_flow_filter`

## Requirements
- R1: After a synchronous reset, tx_pause, fifo_wr and spc_irq are low, all four match registers hold 0x00, the mode is off and the unlock bit is clear.
- R2: With feature bits [1:0] = 00 (off), every character presented with rx_valid appears on fifo_data with fifo_wr high in the next cycle, and tx_pause does not change.
- R3: Configuration address 1 holds resume-first, 2 resume-second, 3 halt-first and 4 halt-second. A write to one of these addresses takes effect only while feature bit 4 (unlock) is 1; otherwise the write is ignored.
- R4: Feature bits [1:0] = 01 select single matching on the resume-first/halt-first pair, and 10 select single matching on the resume-second/halt-second pair. A halt match sets tx_pause and a resume match clears it, one cycle after the character. The character is not written to the FIFO. Characters of the other pair are stored normally.
- R5: Feature bits [1:0] = 11 select pair matching. Halt-first followed by halt-second as the next accepted character sets tx_pause, and resume-first followed by resume-second clears it. Both characters are consumed. Idle cycles between the two characters do not break the pair. tx_pause changes only in the cycle after an accepted character or a feature write.
- R6: In pair mode, a first character followed by a character that does not complete its pair cancels the partial match. The pending first character is discarded, tx_pause is unchanged, and the breaking character is processed as if no partial match existed, which includes starting a new pair.
- R7: When a character matches both the resume and the halt character of the active set, the halt action wins.
- R8: While feature bit 5 is 1, a received character equal to halt-second produces spc_irq high for exactly the next cycle, in any mode. The character's storage follows the flow rules. While bit 5 is 0, spc_irq stays low.
- R9: A write to the feature register (address 0) discards any partial pair. If the written mode is off, tx_pause is released in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 feature, 1..4 match characters) |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | 8 | Character written to the receive FIFO |
| tx_pause | output | 1 | Transmitter pause level |
| spc_irq | output | 1 | Special-character interrupt request pulse |

## Verification
The stimulus focuses on broken pairs. It sends a halt-first followed by a normal byte, a repeated halt-first that has to restart the pair, and a resume-first followed by a halt-first. A design that forgot to cancel would complete the pair on a stray byte. A design that dropped the breaking character would lose data or miss the new pair. The bench also aliases resume-second onto halt-second to check halt precedence. It writes the match registers while locked, where a leaky unlock would make the new value act as a flow character. It toggles special detection to catch an interrupt raised while disabled or held longer than one cycle. Every stored byte passes through a scoreboard queue, so a consumed character that leaks into the FIFO, or a normal one that is swallowed, shows up as a mismatch.

// File: rtl/sw_flow_pkg.sv
package sw_flow_pkg;

    localparam int CHAR_W = 8;
    localparam int ADDR_W = 3;
    localparam int N_MATCH = 4;

    localparam logic [ADDR_W-1:0] ADR_FEAT  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ON1   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_ON2   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_OFF1  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_OFF2  = 3'd4;

    localparam int BIT_UNLOCK = 4;
    localparam int BIT_SPC_EN = 5;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_PAIR1 = 2'b01,
        MODE_PAIR2 = 2'b10,
        MODE_SEQ   = 2'b11
    } fc_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_ON1  = 2'b01,
        SEQ_OFF1 = 2'b10
    } fc_seq_e;

    typedef struct packed {
        logic [CHAR_W-1:0] on1;
        logic [CHAR_W-1:0] on2;
        logic [CHAR_W-1:0] off1;
        logic [CHAR_W-1:0] off2;
    } fc_chars_t;

    typedef struct packed {
        logic     unlock;
        logic     spc_en;
        fc_mode_e mode;
    } fc_ctrl_t;

    typedef struct packed {
        logic on1;
        logic on2;
        logic off1;
        logic off2;
    } fc_hits_t;

    typedef struct packed {
        logic resume;
        logic halt;
    } fc_act_t;

    function automatic fc_act_t single_action(fc_mode_e m, fc_hits_t h);
        fc_act_t a;
        a = '0;
        case (m)
            MODE_PAIR1: begin a.halt = h.off1; a.resume = h.on1; end
            MODE_PAIR2: begin a.halt = h.off2; a.resume = h.on2; end
            default:    a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sw_flow_regs.sv
module sw_flow_regs
    import sw_flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CHAR_W-1:0] cfg_wdata,
    output fc_ctrl_t          ctrl,
    output fc_chars_t         chars,
    output logic              feat_wr,
    output fc_mode_e          feat_mode
);

    logic chr_wr;

    assign feat_wr   = cfg_we && (cfg_addr == ADR_FEAT);
    assign feat_mode = fc_mode_e'(cfg_wdata[1:0]);
    assign chr_wr    = cfg_we && ctrl.unlock;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            chars <= '0;
        end else begin
            if (feat_wr) begin
                ctrl.unlock <= cfg_wdata[BIT_UNLOCK];
                ctrl.spc_en <= cfg_wdata[BIT_SPC_EN];
                ctrl.mode   <= feat_mode;
            end
            if (chr_wr) begin
                case (cfg_addr)
                    ADR_ON1:  chars.on1  <= cfg_wdata;
                    ADR_ON2:  chars.on2  <= cfg_wdata;
                    ADR_OFF1: chars.off1 <= cfg_wdata;
                    ADR_OFF2: chars.off2 <= cfg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    // R3: a locked write to a match address leaves all match characters untouched
    a_r3_locked_chars_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr != ADR_FEAT && !ctrl.unlock) |=> $stable(chars));

endmodule

// File: rtl/sw_flow_match.sv
module sw_flow_match
    import sw_flow_pkg::*;
(
    input  fc_chars_t         chars,
    input  logic [CHAR_W-1:0] rx_data,
    output fc_hits_t          hits
);

    logic [N_MATCH-1:0][CHAR_W-1:0] ref_chars;
    logic [N_MATCH-1:0]             hit_vec;

    assign ref_chars = {chars.on1, chars.on2, chars.off1, chars.off2};

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
        assign hit_vec[i] = (rx_data == ref_chars[i]);
    end

    assign hits = fc_hits_t'(hit_vec);

endmodule

// File: rtl/sw_flow_fsm.sv
module sw_flow_fsm
    import sw_flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  fc_hits_t          hits,
    input  fc_mode_e          mode,
    input  logic              spc_en,
    input  logic              feat_wr,
    input  fc_mode_e          feat_mode,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_data,
    output logic              tx_pause,
    output logic              spc_irq
);

    fc_seq_e seq_q, seq_d;
    fc_act_t act;
    logic    consume;
    logic    pause_d;

    always_comb begin
        seq_d   = seq_q;
        consume = 1'b0;
        pause_d = tx_pause;
        act     = single_action(mode, hits);
        if (rx_valid) begin
            if (mode == MODE_SEQ) begin
                if (seq_q == SEQ_OFF1 && hits.off2) begin
                    consume = 1'b1;
                    pause_d = 1'b1;
                    seq_d   = SEQ_IDLE;
                end else if (seq_q == SEQ_ON1 && hits.on2) begin
                    consume = 1'b1;
                    pause_d = 1'b0;
                    seq_d   = SEQ_IDLE;
                end else if (hits.off1) begin
                    consume = 1'b1;
                    seq_d   = SEQ_OFF1;
                end else if (hits.on1) begin
                    consume = 1'b1;
                    seq_d   = SEQ_ON1;
                end else begin
                    seq_d   = SEQ_IDLE;
                end
            end else if (act.halt) begin
                consume = 1'b1;
                pause_d = 1'b1;
            end else if (act.resume) begin
                consume = 1'b1;
                pause_d = 1'b0;
            end
        end
        if (feat_wr) begin
            seq_d = SEQ_IDLE;
            if (feat_mode == MODE_OFF) pause_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q     <= SEQ_IDLE;
            tx_pause  <= 1'b0;
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            spc_irq   <= 1'b0;
        end else begin
            seq_q     <= seq_d;
            tx_pause  <= pause_d;
            fifo_wr   <= rx_valid && !consume;
            fifo_data <= rx_data;
            spc_irq   <= rx_valid && spc_en && hits.off2;
        end
    end

    // R2: with flow control off every character reaches the FIFO unchanged
    a_r2_off_mode_stores: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode == MODE_OFF) |=> (fifo_wr && fifo_data == $past(rx_data)));

    // R5: the pause level only moves after a character or a feature write
    a_r5_pause_moves_on_event: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !feat_wr) |=> $stable(tx_pause));

    // R6: a partial pair can only exist in pair mode
    a_r6_partial_only_in_seq: assert property (@(posedge clk) disable iff (rst)
        (seq_q != SEQ_IDLE) |-> (mode == MODE_SEQ));

    // R8: no interrupt request without an enabled, received character
    a_r8_irq_needs_char: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid || !spc_en) |=> !spc_irq);

    // R9: selecting the off mode releases the pause
    a_r9_off_releases: assert property (@(posedge clk) disable iff (rst)
        (feat_wr && feat_mode == MODE_OFF) |=> !tx_pause);

endmodule

// File: rtl/sw_flow_filter.sv
module sw_flow_filter
    import sw_flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CHAR_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_data,
    output logic              tx_pause,
    output logic              spc_irq
);

    fc_ctrl_t  ctrl;
    fc_chars_t chars;
    fc_hits_t  hits;
    logic      feat_wr;
    fc_mode_e  feat_mode;
    logic      unused_unlock;

    assign unused_unlock = ctrl.unlock;

    sw_flow_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .chars     (chars),
        .feat_wr   (feat_wr),
        .feat_mode (feat_mode)
    );

    sw_flow_match u_match (
        .chars   (chars),
        .rx_data (rx_data),
        .hits    (hits)
    );

    sw_flow_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .hits      (hits),
        .mode      (ctrl.mode),
        .spc_en    (ctrl.spc_en),
        .feat_wr   (feat_wr),
        .feat_mode (feat_mode),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .tx_pause  (tx_pause),
        .spc_irq   (spc_irq)
    );

    // R1: nothing leaves the block in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!fifo_wr && !spc_irq && !tx_pause));

endmodule

// File: tb/sw_flow_filter_tb_top.sv
module sw_flow_filter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       tx_pause;
    logic       spc_irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_flow_filter dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .tx_pause(tx_pause),
        .spc_irq(spc_irq)
    );

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: presents one character and records whether it must be stored
    task automatic send(logic [7:0] c, bit store, string req);
        @(negedge clk);
        if (store) begin
            exp_q.push_back(c);
            tag_q.push_back(req);
        end
        rx_valid = 1'b1; rx_data = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // monitor: compares every FIFO write with the head of the queue
    always @(negedge clk) begin
        if (!rst && fifo_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected fifo write actual=%02h expected=none", fifo_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (fifo_data !== e) begin
                    fails++;
                    $display("FAIL %s fifo data actual=%02h expected=%02h", t, fifo_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, all R tags unfinished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        rx_valid = 1'b0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_bit("R1", "tx_pause", tx_pause, 1'b0);
        check_bit("R1", "fifo_wr", fifo_wr, 1'b0);
        check_bit("R1", "spc_irq", spc_irq, 1'b0);
        send(8'h00, 1, "R1");   // mode off, match regs zero: stored
        check_bit("R1", "tx_pause after 00", tx_pause, 1'b0);

        // unlock and program characters, mode still off
        cfg_write(3'd0, 8'h10);
        cfg_write(3'd1, 8'h11);
        cfg_write(3'd2, 8'h12);
        cfg_write(3'd3, 8'h13);
        cfg_write(3'd4, 8'h14);
        send(8'h13, 1, "R2");
        send(8'h41, 1, "R2");
        check_bit("R2", "tx_pause in off mode", tx_pause, 1'b0);

        // R3: locked, pair1 mode, halt-first write ignored
        cfg_write(3'd0, 8'h01);
        cfg_write(3'd3, 8'h55);
        send(8'h55, 1, "R3");
        check_bit("R3", "tx_pause after locked write", tx_pause, 1'b0);
        // R4: pair1
        send(8'h13, 0, "R4");
        check_bit("R4", "pause set by halt-first", tx_pause, 1'b1);
        send(8'h14, 1, "R4");
        check_bit("R4", "pause kept on other pair", tx_pause, 1'b1);
        send(8'h11, 0, "R4");
        check_bit("R4", "pause cleared by resume-first", tx_pause, 1'b0);

        // R4: pair2
        cfg_write(3'd0, 8'h12);
        send(8'h13, 1, "R4");
        send(8'h14, 0, "R4");
        check_bit("R4", "pause set by halt-second", tx_pause, 1'b1);
        send(8'h12, 0, "R4");
        check_bit("R4", "pause cleared by resume-second", tx_pause, 1'b0);

        // R7: resume-second aliased onto halt-second
        cfg_write(3'd2, 8'h14);
        send(8'h14, 0, "R7");
        check_bit("R7", "halt wins on alias", tx_pause, 1'b1);
        cfg_write(3'd2, 8'h12);
        send(8'h12, 0, "R7");
        check_bit("R7", "release after restore", tx_pause, 1'b0);

        // R5: pair mode
        cfg_write(3'd0, 8'h13);
        send(8'h13, 0, "R5");
        check_bit("R5", "no pause after half pair", tx_pause, 1'b0);
        send(8'h14, 0, "R5");
        check_bit("R5", "pause after full halt pair", tx_pause, 1'b1);
        send(8'h11, 0, "R5");
        repeat (3) @(negedge clk);
        check_bit("R5", "pause held during half resume", tx_pause, 1'b1);
        send(8'h12, 0, "R5");
        check_bit("R5", "resume pair with gap", tx_pause, 1'b0);

        // R6: broken pairs
        send(8'h13, 0, "R6");
        send(8'h41, 1, "R6");
        check_bit("R6", "broken halt pair", tx_pause, 1'b0);
        send(8'h13, 0, "R6");
        send(8'h13, 0, "R6");
        send(8'h14, 0, "R6");
        check_bit("R6", "restarted halt pair", tx_pause, 1'b1);
        send(8'h11, 0, "R6");
        send(8'h13, 0, "R6");
        check_bit("R6", "pause kept after switch", tx_pause, 1'b1);
        send(8'h11, 0, "R6");
        send(8'h12, 0, "R6");
        check_bit("R6", "resume after restart", tx_pause, 1'b0);

        // R8: special character detection
        cfg_write(3'd0, 8'h33);
        send(8'h14, 1, "R8");
        check_bit("R8", "irq pulse", spc_irq, 1'b1);
        @(negedge clk);
        check_bit("R8", "irq one cycle", spc_irq, 1'b0);
        send(8'h41, 1, "R8");
        check_bit("R8", "no irq on other char", spc_irq, 1'b0);
        cfg_write(3'd0, 8'h13);
        send(8'h14, 1, "R8");
        check_bit("R8", "no irq when disabled", spc_irq, 1'b0);

        // R9: feature writes
        send(8'h13, 0, "R9");
        send(8'h14, 0, "R9");
        check_bit("R9", "pause before off write", tx_pause, 1'b1);
        cfg_write(3'd0, 8'h10);
        check_bit("R9", "off write releases pause", tx_pause, 1'b0);
        cfg_write(3'd0, 8'h13);
        send(8'h11, 0, "R9");
        cfg_write(3'd0, 8'h13);
        send(8'h12, 1, "R9");
        check_bit("R9", "partial discarded by write", tx_pause, 1'b0);

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing fifo writes actual=%0d expected=0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule